// File: doc/BRIEF.md
# Pause-Width Bit Demodulator

This block recovers the downlink bits that a reader sends to a contactless tag. The reader marks the start of each bit by switching its field off for a short pause. The time until the next pause start gives the bit value. All timing is counted on a tick enable that runs at the 212 kHz subcarrier rate, so one tick is about 4.7 us. The field-present input is asynchronous. It is synchronized inside the block and read only on ticks.

The first pause opens a frame. Every later pause start closes the interval that began at the pause before it. That interval is then sorted as a 1, a 0 or a code violation. The encoding has no stop symbol. A frame ends at its first code violation, and it is accepted only if its bit count lies in a legal range. The block also reports the tick count at which the accepted frame ended. An external descrambler and the tag protocol logic use its per-bit strobe and its frame outcome.

Top module: `pause_width_demod`

## Requirements
- R1: After a synchronous reset, every strobe output is 0, `bitCount` is 0 and `frameEndTs` is 0.
- R2: An interval of 18 to 30 ticks between pause starts decodes as `bitValue`=1, and an interval of 4 to 17 ticks decodes as `bitValue`=0. Each decoded bit gives a one-cycle `bitValid` pulse.
- R3: An interval of fewer than 4 ticks between two pause starts is a code violation.
- R4: If no new pause starts within 31 ticks of the current bit's pause start, a code violation is raised on exactly the 31st tick.
- R5: A code violation after 6 to 23 decoded bits gives a one-cycle `frameDone` pulse. `bitCount` holds the number of decoded bits.
- R6: A code violation after fewer than 6 or more than 23 decoded bits gives a one-cycle `frameError` pulse and no `frameDone`.
- R7: On `frameDone`, `frameEndTs` equals the tick index (ticks counted from 0 after reset) at which the final pause started, plus 4.
- R8: While the block waits for a frame, a `frameError` pulse is raised if no pause starts within 840 ticks (40 periods of 21 ticks). Counting starts from reset or from the end of the previous frame, and the wait then begins again.
- R9: The field level is taken only at tick enables. A pause that begins and ends between two ticks starts no frame and decodes no bit.
- R10: Each frame ends with exactly one `codeViol` pulse, in the same cycle as its `frameDone` or `frameError`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle enable at the subcarrier rate |
| fieldIn | input | 1 | Field present (1) or paused (0), asynchronous |
| bitValid | output | 1 | Decoded bit strobe |
| bitValue | output | 1 | Decoded bit value, valid with `bitValid` |
| codeViol | output | 1 | Code violation strobe |
| frameDone | output | 1 | Frame accepted strobe |
| frameError | output | 1 | Frame rejected or start-of-frame timeout strobe |
| bitCount | output | 5 | Bits decoded in the current or last frame |
| frameEndTs | output | 16 | Tick index of the last accepted frame end |

## Verification
The assertions assume that `tickEn` is a single-cycle pulse spaced several clocks apart. They also assume that `fieldIn` settles at least two clocks before the tick that samples it. The bench keeps to both rules by building each tick slot from four clocks. It changes the field only at the start of a slot and raises the tick on the slot's last clock. The one exception is the glitch scenario, which drops the field for a single clock inside a slot. Even there the level is restored well before the tick.

// File: rtl/pwd_pkg.sv
`timescale 1ns/1ps
package pwd_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic startBit;  // restart interval counter, capture bit start time
    logic clrIdle;   // restart start-of-frame wait counter
    logic capEnd;    // latch frame end timestamp
  } dpCtl_t;

  typedef enum logic {ST_WAIT, ST_RX} rxState_t;
endpackage

// File: rtl/pwd_datapath.sv
`timescale 1ns/1ps
module pwd_datapath
  import pwd_pkg::*;
#(
  parameter int PAUSE_TICKS = 4,
  parameter int BIT_LIMIT   = 31,
  parameter int SOF_LIMIT   = 840,
  parameter int IV_W        = 5,
  parameter int IDLE_W      = 10,
  parameter int TS_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              fieldIn,
  input  dpCtl_t            ctl,
  output logic              pauseEdge,
  output logic [IV_W:0]     ivNext,
  output logic [IDLE_W-1:0] idleNext,
  output logic [TS_W-1:0]   frameEndTs
);
  logic [1:0]        syncQ;
  logic              fieldSync;
  logic              fieldTick;
  logic [TS_W-1:0]   tsCnt;
  logic [TS_W-1:0]   bitStartTs;
  logic [IV_W-1:0]   ivCnt;
  logic [IDLE_W-1:0] idleCnt;

  assign fieldSync = syncQ[1];
  // falling field level seen between two consecutive ticks
  assign pauseEdge = tickEn & fieldTick & ~fieldSync;
  assign ivNext    = {1'b0, ivCnt} + 1'b1;
  assign idleNext  = idleCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ      <= '0;
      fieldTick  <= 1'b0;
      tsCnt      <= '0;
      bitStartTs <= '0;
      ivCnt      <= '0;
      idleCnt    <= '0;
      frameEndTs <= '0;
    end else begin
      syncQ <= {syncQ[0], fieldIn};
      if (tickEn) begin
        fieldTick <= fieldSync;
        tsCnt     <= tsCnt + 1'b1;
      end
      if (ctl.startBit) begin
        ivCnt      <= '0;
        bitStartTs <= tsCnt;
      end else if (tickEn && ivCnt != IV_W'(BIT_LIMIT)) begin
        ivCnt <= ivCnt + 1'b1;
      end
      if (ctl.clrIdle)   idleCnt <= '0;
      else if (tickEn)   idleCnt <= idleCnt + 1'b1;
      if (ctl.capEnd)    frameEndTs <= bitStartTs + TS_W'(PAUSE_TICKS);
    end
  end

  // R8: control must restart the wait counter before it reaches the limit
  p_idle_bound_r8: assert property (@(posedge clk) disable iff (rst)
    idleCnt < IDLE_W'(SOF_LIMIT));
endmodule

// File: rtl/pwd_ctrl.sv
`timescale 1ns/1ps
module pwd_ctrl
  import pwd_pkg::*;
#(
  parameter int PAUSE_TICKS = 4,
  parameter int THRESH      = 17,
  parameter int BIT_LIMIT   = 31,
  parameter int SOF_LIMIT   = 840,
  parameter int MIN_BITS    = 6,
  parameter int MAX_BITS    = 23,
  parameter int CNT_W       = 5,
  parameter int IV_W        = 5,
  parameter int IDLE_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              pauseEdge,
  input  logic [IV_W:0]     ivNext,
  input  logic [IDLE_W-1:0] idleNext,
  output dpCtl_t            ctl,
  output logic              bitValid,
  output logic              bitValue,
  output logic              codeViol,
  output logic              frameDone,
  output logic              frameError,
  output logic [CNT_W-1:0]  bitCount
);
  localparam int IVN_W = IV_W + 1;

  rxState_t state;
  logic tooLong, tooShort, inRange, violation, bitOk, sofTimeout;

  always_comb begin
    inRange    = (bitCount >= CNT_W'(MIN_BITS)) && (bitCount <= CNT_W'(MAX_BITS));
    tooLong    = ivNext >= IVN_W'(BIT_LIMIT);
    tooShort   = ivNext < IVN_W'(PAUSE_TICKS);
    violation  = tickEn && (state == ST_RX) && (tooLong || (pauseEdge && tooShort));
    bitOk      = tickEn && (state == ST_RX) && !tooLong && pauseEdge && !tooShort;
    sofTimeout = tickEn && (state == ST_WAIT) && !pauseEdge && (idleNext >= IDLE_W'(SOF_LIMIT));
    ctl.startBit = ((state == ST_WAIT) && pauseEdge) || bitOk;
    ctl.clrIdle  = (state == ST_RX) || sofTimeout || ctl.startBit;
    ctl.capEnd   = violation && inRange;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_WAIT;
      bitValid   <= 1'b0;
      bitValue   <= 1'b0;
      codeViol   <= 1'b0;
      frameDone  <= 1'b0;
      frameError <= 1'b0;
      bitCount   <= '0;
    end else begin
      bitValid   <= 1'b0;
      codeViol   <= 1'b0;
      frameDone  <= 1'b0;
      frameError <= 1'b0;
      if ((state == ST_WAIT) && ctl.startBit) begin
        state    <= ST_RX;
        bitCount <= '0;
      end
      if (sofTimeout) frameError <= 1'b1;
      if (bitOk) begin
        bitValid <= 1'b1;
        bitValue <= ivNext > IVN_W'(THRESH);
        if (bitCount != '1) bitCount <= bitCount + 1'b1;
      end
      if (violation) begin
        codeViol   <= 1'b1;
        frameDone  <= inRange;
        frameError <= !inRange;
        state      <= ST_WAIT;
      end
    end
  end

  // R5: an accepted frame always has a legal length
  p_done_range_r5: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> (bitCount >= CNT_W'(MIN_BITS) && bitCount <= CNT_W'(MAX_BITS)));
  // R6: accept and reject never coincide
  p_end_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frameDone, frameError}));
  // R10: every violation closes the frame one way or the other
  p_viol_closes_r10: assert property (@(posedge clk) disable iff (rst)
    codeViol |-> (frameDone || frameError));
  // R9: decode events only follow a tick
  p_tick_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    (bitValid || codeViol) |-> $past(tickEn));
endmodule

// File: rtl/pause_width_demod.sv
`timescale 1ns/1ps
module pause_width_demod
  import pwd_pkg::*;
#(
  parameter int PAUSE_TICKS = 4,
  parameter int BIT0_TICKS  = 13,
  parameter int BIT1_TICKS  = 21,
  parameter int SOF_BITS    = 40,
  parameter int MIN_BITS    = 6,
  parameter int MAX_BITS    = 23,
  parameter int CNT_W       = 5,
  parameter int TS_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             fieldIn,
  output logic             bitValid,
  output logic             bitValue,
  output logic             codeViol,
  output logic             frameDone,
  output logic             frameError,
  output logic [CNT_W-1:0] bitCount,
  output logic [TS_W-1:0]  frameEndTs
);
  localparam int THRESH    = (BIT0_TICKS + BIT1_TICKS) / 2;
  localparam int BIT_LIMIT = BIT1_TICKS * 3 / 2;
  localparam int SOF_LIMIT = SOF_BITS * BIT1_TICKS;
  localparam int IV_W      = $clog2(BIT_LIMIT + 1);
  localparam int IDLE_W    = $clog2(SOF_LIMIT + 1);

  dpCtl_t            ctl;
  logic              pauseEdge;
  logic [IV_W:0]     ivNext;
  logic [IDLE_W-1:0] idleNext;

  pwd_datapath #(
    .PAUSE_TICKS(PAUSE_TICKS), .BIT_LIMIT(BIT_LIMIT), .SOF_LIMIT(SOF_LIMIT),
    .IV_W(IV_W), .IDLE_W(IDLE_W), .TS_W(TS_W)
  ) dp_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .fieldIn(fieldIn), .ctl(ctl),
    .pauseEdge(pauseEdge), .ivNext(ivNext), .idleNext(idleNext),
    .frameEndTs(frameEndTs)
  );

  pwd_ctrl #(
    .PAUSE_TICKS(PAUSE_TICKS), .THRESH(THRESH), .BIT_LIMIT(BIT_LIMIT),
    .SOF_LIMIT(SOF_LIMIT), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS),
    .CNT_W(CNT_W), .IV_W(IV_W), .IDLE_W(IDLE_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .pauseEdge(pauseEdge),
    .ivNext(ivNext), .idleNext(idleNext), .ctl(ctl),
    .bitValid(bitValid), .bitValue(bitValue), .codeViol(codeViol),
    .frameDone(frameDone), .frameError(frameError), .bitCount(bitCount)
  );
endmodule

// File: tb/pause_width_demod_tb_top.sv
`timescale 1ns/1ps
module pause_width_demod_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic        fieldIn = 1'b1;
  logic        bitValid, bitValue, codeViol, frameDone, frameError;
  logic [4:0]  bitCount;
  logic [15:0] frameEndTs;

  int nChecks = 0;
  int nFails  = 0;
  int tickNo  = 0;
  int nBits = 0, nViol = 0, nDone = 0, nErr = 0;
  int rxBits [64];
  int wid [32];
  int pl  [32];
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  pause_width_demod dut_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .fieldIn(fieldIn),
    .bitValid(bitValid), .bitValue(bitValue), .codeViol(codeViol),
    .frameDone(frameDone), .frameError(frameError),
    .bitCount(bitCount), .frameEndTs(frameEndTs)
  );

  // event monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bitValid) begin
        if (nBits < 64) rxBits[nBits] = bitValue;
        nBits++;
      end
      if (codeViol)   nViol++;
      if (frameDone)  nDone++;
      if (frameError) nErr++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; tickEn = 1'b0; fieldIn = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tickNo = 0; nBits = 0; nViol = 0; nDone = 0; nErr = 0;
    #1;
  endtask

  // one tick slot of four clocks; the field holds `level` at the tick
  task automatic slot(input logic level, input bit glitch = 0);
    if (glitch) begin
      fieldIn = 1'b0;
      @(negedge clk);
      fieldIn = level;
      repeat (2) @(negedge clk);
    end else begin
      fieldIn = level;
      repeat (3) @(negedge clk);
    end
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    tickNo++;
    #1;
  endtask

  task automatic sendBit(input int w, input int p);
    repeat (p) slot(1'b0);
    repeat (w - p) slot(1'b1);
  endtask

  task automatic runFrame(input int n, input string tag);
    int fin; bit expDone; int bad;
    doReset();
    repeat (3) slot(1'b1);
    for (int i = 0; i < n; i++) sendBit(wid[i], pl[i]);
    fin = tickNo;
    repeat (4) slot(1'b0);
    repeat (40) slot(1'b1);
    expDone = (n >= 6) && (n <= 23);
    check(nBits == n, {tag, " R2"}, "decoded bit count", nBits, n);
    bad = 0;
    for (int i = 0; i < n && i < 64; i++)
      if (rxBits[i] != ((wid[i] > 17) ? 1 : 0)) bad++;
    check(bad == 0, {tag, " R2"}, "wrong bit values", bad, 0);
    check(nViol == 1, {tag, " R10"}, "violation pulses", nViol, 1);
    check(nDone == int'(expDone), {tag, " R5"}, "done pulses", nDone, int'(expDone));
    check(nErr == int'(!expDone), {tag, " R6"}, "error pulses", nErr, int'(!expDone));
    check(int'(bitCount) == n, {tag, " R5"}, "bitCount", bitCount, n);
    if (expDone)
      check(int'(frameEndTs) == fin + 4, {tag, " R7"}, "frameEndTs", frameEndTs, fin + 4);
  endtask

  task automatic fillWidths(input int n, input int w);
    for (int i = 0; i < n; i++) begin wid[i] = w; pl[i] = 4; end
  endtask

  task automatic testReset();
    doReset();
    check({bitValid, bitValue, codeViol, frameDone, frameError} == 5'b0, "R1",
          "strobes after reset", {bitValid, bitValue, codeViol, frameDone, frameError}, 0);
    check(bitCount == 0, "R1", "bitCount after reset", bitCount, 0);
    check(frameEndTs == 0, "R1", "frameEndTs after reset", frameEndTs, 0);
  endtask

  task automatic testSofTimeout();
    doReset();
    repeat (835) slot(1'b1);
    check(nErr == 0, "R8", "early start timeout", nErr, 0);
    repeat (10) slot(1'b1);
    check(nErr == 1, "R8", "start timeout at 840 ticks", nErr, 1);
    check(nViol == 0, "R8", "no violation on start timeout", nViol, 0);
  endtask

  task automatic testMixed();
    int w[8] = '{21, 13, 21, 21, 13, 13, 21, 13};
    for (int i = 0; i < 8; i++) begin wid[i] = w[i]; pl[i] = 4; end
    runFrame(8, "mixed");
  endtask

  task automatic testThresholds();
    int w[6] = '{17, 18, 30, 4, 16, 21};
    for (int i = 0; i < 6; i++) begin wid[i] = w[i]; pl[i] = (w[i] == 4) ? 2 : 4; end
    runFrame(6, "threshold");
  endtask

  task automatic testShortViol();
    int vs;
    doReset();
    repeat (3) slot(1'b1);
    repeat (7) sendBit(21, 4);
    vs = tickNo;
    sendBit(3, 1);
    slot(1'b0);
    repeat (40) slot(1'b1);
    check(nBits == 7, "R3", "bits before short interval", nBits, 7);
    check(nViol == 1, "R3", "short interval violation", nViol, 1);
    check(nDone == 1, "R3", "frame accepted", nDone, 1);
    check(int'(frameEndTs) == vs + 4, "R7", "end ts after short violation", frameEndTs, vs + 4);
  endtask

  task automatic testTimeoutEdge();
    doReset();
    repeat (3) slot(1'b1);
    repeat (6) sendBit(13, 4);
    repeat (4) slot(1'b0);
    repeat (27) slot(1'b1);
    check(nViol == 0, "R4", "violation before 31 ticks", nViol, 0);
    slot(1'b1);
    check(nViol == 1, "R4", "violation on tick 31", nViol, 1);
    check(nDone == 1, "R5", "six-bit frame accepted", nDone, 1);
  endtask

  task automatic testGlitch();
    doReset();
    repeat (3) slot(1'b1);
    repeat (30) slot(1'b1, 1'b1);
    repeat (5) slot(1'b1);
    check(nBits == 0, "R9", "bits from glitches", nBits, 0);
    check(nViol + nErr == 0, "R9", "events from glitches", nViol + nErr, 0);
  endtask

  initial begin
    testReset();
    testSofTimeout();
    testMixed();
    testThresholds();
    testShortViol();
    testTimeoutEdge();
    fillWidths(5, 21);  runFrame(5, "five bits R6");
    fillWidths(6, 13);  runFrame(6, "six bits R5");
    fillWidths(23, 13); runFrame(23, "23 bits R5");
    fillWidths(24, 13); runFrame(24, "24 bits R6");
    testGlitch();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule